// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a memory-mapped watchdog for a chip-level reset path. A 24-bit down-counter advances once every four clocks and, while running, must be reloaded by software before it drains. A reload is accepted only as a two-write key sequence on the feed register: first 0xAA, then 0x55. Once enabled, the watchdog cannot be switched off, and its reset mode cannot be withdrawn. A key sequence that is broken, either by a wrong second value or by any other register access in between, is treated as a software fault and requests a reset at once.

Software sets the reload value, sets the enable bit (and optionally the reset-mode bit), and then performs one good feed. Counting begins only at that feed. When the counter runs out, a sticky expiry flag is raised. If reset mode is set, a four-cycle reset request pulse is also issued. The register port is single-cycle: a write or read strobe together with an address counts as one access in the cycle it is presented.

Top module: `keyfeed_wdt`

## Requirements
- R1: After system reset the control register reads 0, the reload register reads 0xFF, the counter reads 0xFF, and `sys_reset_req` and `expired_flag` are low.
- R2: A write to the reload register (byte offset 0x04) stores bits 23:0 of the write data. A value below 0xFF is stored as 0xFF. Reading offset 0x04 returns the stored value.
- R3: In the control register (offset 0x00), bit 0 is enable and bit 1 is reset mode. Writing a 1 sets a bit, and writing a 0 never clears it. Bit 2 is the expiry flag, and software writes do not change it.
- R4: The counter holds its value until a good feed occurs while enable is set. A good feed while enable is clear reloads the counter but does not start it.
- R5: A good feed is a write of 0xAA (bits 7:0) to the feed register (offset 0x08), followed by a write of 0x55 to the same register as the next access. Idle cycles between the two writes are allowed. A good feed loads the counter from the reload register and restarts the divide-by-4 phase.
- R6: While running, the counter decreases by one every 4 clocks, with the first step 4 clocks after the feed. A read at offset 0x0C returns the live count.
- R7: A divide-by-4 step taken while the running count is 0 sets the expiry flag, which stays set until system reset. Counting then stops at 0.
- R8: On expiry with reset mode set, `sys_reset_req` goes high for exactly 4 cycles, starting the cycle after the expiry step. With reset mode clear, expiry raises no request.
- R9: With enable set, a feed-register write after 0xAA whose value is not 0x55 raises `sys_reset_req` for 4 cycles, starting the cycle after that write.
- R10: Any other access after 0xAA (a read, or a write to another offset) cancels the key sequence. With enable set this is treated as R9. With enable clear it raises no request. The interrupting access itself still takes effect.
- R11: When no key sequence is pending, feed-register writes other than 0xAA change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst_n | input | 1 | Synchronous active-low system reset |
| reg_addr | input | 4 | Byte offset; bits 3:2 select the register |
| reg_we | input | 1 | Write strobe, one access per cycle |
| reg_re | input | 1 | Read strobe, one access per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sys_reset_req | output | 1 | Chip reset request pulse |
| expired_flag | output | 1 | Sticky expiry status |

## Verification
Most internal faults reach the ports quickly. A wrong key-sequence state shows up as a missing or extra `sys_reset_req` pulse in the cycle right after the second access. It can also show up as a counter that fails to reload, which is visible on the next read of offset 0x0C. A wrong divider phase or decrement moves the count read at offset 0x0C by one within 4 to 12 cycles of a feed. A wrong expiry condition shifts the rise of `expired_flag` away from exactly 4×(reload+1) cycles after the feed. Control bits that software can clear are caught by reading back offset 0x00 straight after a write of zeros.

// File: rtl/keyfeed_wdt_pkg.sv
// Shared constants and types for the keyed-feed watchdog.
// Assumes 32-bit bus data and a 4-bit byte address with word-aligned registers.
package keyfeed_wdt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 24;
    localparam int KEY_W  = 8;

    // Register select from address bits 3:2
    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_RELOAD = 2'd1;
    localparam logic [1:0] SEL_FEED   = 2'd2;
    localparam logic [1:0] SEL_COUNT  = 2'd3;

    localparam logic [KEY_W-1:0] KEY_OPEN  = 8'hAA;
    localparam logic [KEY_W-1:0] KEY_CLOSE = 8'h55;

    typedef enum logic {
        KEY_WAIT_OPEN  = 1'b0,
        KEY_WAIT_CLOSE = 1'b1
    } key_state_t;
endpackage

// File: rtl/wdt_prescale.sv
// Divide-by-DIV tick generator.
// Emits a one-cycle tick on every DIV-th clock. A clear restarts the phase so
// the first tick comes DIV clocks after the clear.
module wdt_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Phase counter: wraps at DIV-1, forced to zero on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == LAST);

    // R6: after a clear the tick is quiet on the next cycle
    p_clear_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick);
endmodule

// File: rtl/wdt_key_seq.sv
// Two-write feed key sequencer.
// Watches every bus access. It opens on a feed write of the first key and
// closes on the next access: good when it is a feed write of the second key,
// bad otherwise. It assumes at most one access per cycle.
module wdt_key_seq
    import keyfeed_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access,
    input  logic             feed_wr,
    input  logic [KEY_W-1:0] key,
    output logic             good,
    output logic             bad
);
    key_state_t state_q;
    logic       close_ok;

    // Outcome decode for the access that ends an open sequence
    always_comb begin
        close_ok = feed_wr && (key == KEY_CLOSE);
        good     = (state_q == KEY_WAIT_CLOSE) && access && close_ok;
        bad      = (state_q == KEY_WAIT_CLOSE) && access && !close_ok;
    end

    // Sequence state: any access while open closes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KEY_WAIT_OPEN;
        end else if (access) begin
            if (state_q == KEY_WAIT_CLOSE) begin
                state_q <= KEY_WAIT_OPEN;
            end else if (feed_wr && key == KEY_OPEN) begin
                state_q <= KEY_WAIT_CLOSE;
            end
        end
    end

    // R5: an open sequence can end only one way
    p_single_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({good, bad}));
    // R11: stray feed values leave an idle sequencer idle
    p_stray_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_WAIT_OPEN && feed_wr && key != KEY_OPEN) |=> (state_q == KEY_WAIT_OPEN));
endmodule

// File: rtl/wdt_countdown.sv
// Watchdog down-counter.
// Loads on a good feed and runs only if enable was set at that feed. It steps
// down on each prescaler tick and flags expiry on a tick at zero, then stops.
module wdt_countdown #(
    parameter int                CNT_W     = 24,
    parameter logic [CNT_W-1:0]  RESET_VAL = 24'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             start,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] count_q;
    logic             run_q;

    assign expire = run_q && tick && (count_q == '0) && !load;
    assign count  = count_q;

    // Count register and run state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= RESET_VAL;
            run_q   <= 1'b0;
        end else if (load) begin
            count_q <= load_val;
            run_q   <= start;
        end else if (expire) begin
            run_q   <= 1'b0;
        end else if (run_q && tick) begin
            count_q <= count_q - 1'b1;
        end
    end

    // R6: a running step removes exactly one
    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick && count_q != '0 && !load) |=> (count_q == $past(count_q) - CNT_W'(1)));
    // R4: idle counter holds its value
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load) |=> $stable(count_q));
    // R7: counting stops once expired
    p_stop_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire) |=> (!run_q && count_q == '0));
endmodule

// File: rtl/wdt_req_pulse.sv
// Fixed-length reset request stretcher.
// Any fire loads LEN cycles of request, and a fire during a pulse restarts it.
module wdt_req_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic req
);
    localparam int LW = $clog2(LEN + 1);

    logic [LW-1:0] left_q;

    // Remaining-cycles counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= LW'(LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign req = (left_q != '0);

    // R8: a fire always shows a request on the next cycle
    p_fire_shows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> req);
    // R8: without a fire the request only ends, never starts
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !req) |=> !req);
endmodule

// File: rtl/keyfeed_wdt.sv
// Keyed-feed watchdog top level.
// Decodes the single-cycle register port and holds the set-only control bits
// and the reload value. It ties together the prescaler, key sequencer,
// counter and reset stretcher. Assumes one bus access per cycle at most.
module keyfeed_wdt
    import keyfeed_wdt_pkg::*;
#(
    parameter int PRESCALE  = 4,
    parameter int PULSE_LEN = 4,
    parameter int RELOAD_MIN = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sys_reset_req,
    output logic              expired_flag
);
    localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(RELOAD_MIN);

    logic [1:0]       sel;
    logic             access, feed_wr, ctrl_wr, reload_wr;
    logic             en_q, rmode_q, flag_q;
    logic [CNT_W-1:0] reload_q, reload_in, reload_next;
    logic             key_good, key_bad, tick, expire, fire;
    logic [CNT_W-1:0] count;
    logic             unused_bits;

    assign unused_bits = ^{reg_wdata[DATA_W-1:CNT_W], reg_addr[1:0]};

    // Bus decode for this cycle's access
    always_comb begin
        sel       = reg_addr[3:2];
        access    = reg_we || reg_re;
        feed_wr   = reg_we && (sel == SEL_FEED);
        ctrl_wr   = reg_we && (sel == SEL_CTRL);
        reload_wr = reg_we && (sel == SEL_RELOAD);
        reload_in = reg_wdata[CNT_W-1:0];
        reload_next = (reload_in < MIN_VAL) ? MIN_VAL : reload_in;
    end

    // Set-only control bits and reload register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            rmode_q  <= 1'b0;
            reload_q <= MIN_VAL;
        end else begin
            if (ctrl_wr) begin
                en_q    <= en_q | reg_wdata[0];
                rmode_q <= rmode_q | reg_wdata[1];
            end
            if (reload_wr) begin
                reload_q <= reload_next;
            end
        end
    end

    // Sticky expiry flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end
    end

    // Read data mux, selected by address alone
    always_comb begin
        unique case (sel)
            SEL_CTRL:   reg_rdata = {{(DATA_W-3){1'b0}}, flag_q, rmode_q, en_q};
            SEL_RELOAD: reg_rdata = {{(DATA_W-CNT_W){1'b0}}, reload_q};
            SEL_COUNT:  reg_rdata = {{(DATA_W-CNT_W){1'b0}}, count};
            default:    reg_rdata = '0;
        endcase
    end

    wdt_prescale #(.DIV(PRESCALE)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (key_good),
        .tick  (tick)
    );

    wdt_key_seq u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .access  (access),
        .feed_wr (feed_wr),
        .key     (reg_wdata[KEY_W-1:0]),
        .good    (key_good),
        .bad     (key_bad)
    );

    wdt_countdown #(.CNT_W(CNT_W), .RESET_VAL(MIN_VAL)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (key_good),
        .load_val (reload_q),
        .start    (en_q),
        .tick     (tick),
        .count    (count),
        .expire   (expire)
    );

    assign fire = (key_bad && en_q) || (expire && rmode_q);

    wdt_req_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .req   (sys_reset_req)
    );

    assign expired_flag = flag_q;

    // R2: reload value never below the floor
    p_reload_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reload_q >= MIN_VAL);
    // R3: enable and reset mode are set-only
    p_en_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);
    p_rmode_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rmode_q |=> rmode_q);
    // R7: expiry flag stays set
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> flag_q);
    // R9: a broken key while enabled requests reset next cycle
    p_bad_key_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (key_bad && en_q) |=> sys_reset_req);
endmodule

// File: tb/keyfeed_wdt_tb.sv
// Directed bench for keyfeed_wdt: one task per scenario, each self-checking.
module keyfeed_wdt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sys_reset_req;
    logic        expired_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    keyfeed_wdt u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_addr      (reg_addr),
        .reg_we        (reg_we),
        .reg_re        (reg_re),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .sys_reset_req (sys_reset_req),
        .expired_flag  (expired_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write access across one rising edge; returns at the following falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // One real read access across one rising edge
    task automatic rd_access(input logic [3:0] a);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    // Look at read data without an access strobe
    task automatic peek(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic feed(input int gap);
        wr(4'h8, 32'hAA);
        repeat (gap) @(negedge clk);
        wr(4'h8, 32'h55);
    endtask

    // Request is already visible now; expect it for 4 samples, then low
    task automatic chk_pulse(input string tag);
        for (int i = 0; i < 5; i++) begin
            if (i > 0) @(negedge clk);
            chk(tag, {31'b0, sys_reset_req}, (i < 4) ? 32'd1 : 32'd0);
        end
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        peek(4'h0, v); chk("R1 ctrl", v, 32'h0);
        peek(4'h4, v); chk("R1 reload", v, 32'hFF);
        peek(4'hC, v); chk("R1 count", v, 32'hFF);
        chk("R1 req", {31'b0, sys_reset_req}, 0);
        chk("R1 flag", {31'b0, expired_flag}, 0);
    endtask

    task automatic t_reload_reg();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h10);       peek(4'h4, v); chk("R2 floor", v, 32'hFF);
        wr(4'h4, 32'hFE);       peek(4'h4, v); chk("R2 floor edge", v, 32'hFF);
        wr(4'h4, 32'h100);      peek(4'h4, v); chk("R2 above floor", v, 32'h100);
        wr(4'h4, 32'hAB001234); peek(4'h4, v); chk("R2 width", v, 32'h1234);
    endtask

    task automatic t_ctrl_sticky();
        logic [31:0] v;
        do_reset();
        wr(4'h0, 32'h1); peek(4'h0, v); chk("R3 set en", v, 32'h1);
        wr(4'h0, 32'h2); peek(4'h0, v); chk("R3 set rmode", v, 32'h3);
        wr(4'h0, 32'h0); peek(4'h0, v); chk("R3 no clear", v, 32'h3);
        wr(4'h0, 32'h4); peek(4'h0, v); chk("R3 flag not writable", v, 32'h3);
    endtask

    task automatic t_feed_disabled();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h300);
        feed(0);
        peek(4'hC, v); chk("R5 reload on feed", v, 32'h300);
        repeat (40) @(negedge clk);
        peek(4'hC, v); chk("R4 not started while disabled", v, 32'h300);
    endtask

    task automatic t_start_count();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h300);
        wr(4'h0, 32'h1);
        repeat (40) @(negedge clk);
        peek(4'hC, v); chk("R4 enable alone holds", v, 32'hFF);
        feed(0);
        peek(4'hC, v); chk("R5 loaded", v, 32'h300);
        repeat (3) @(posedge clk); @(negedge clk);
        peek(4'hC, v); chk("R6 no step before 4 clocks", v, 32'h300);
        @(posedge clk); @(negedge clk);
        peek(4'hC, v); chk("R6 first step", v, 32'h2FF);
        repeat (4) @(posedge clk); @(negedge clk);
        peek(4'hC, v); chk("R6 second step", v, 32'h2FE);
        repeat (40) @(posedge clk); @(negedge clk);
        peek(4'hC, v); chk("R6 live count", v, 32'h2F4);
    endtask

    task automatic t_bad_value();
        logic [31:0] v;
        do_reset();
        wr(4'h0, 32'h1);
        wr(4'h8, 32'hAA);
        chk("R9 no req after open", {31'b0, sys_reset_req}, 0);
        wr(4'h8, 32'h56);
        chk_pulse("R9 bad key pulse");
        peek(4'hC, v); chk("R9 no reload on bad key", v, 32'hFF);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        do_reset();
        wr(4'h0, 32'h1);
        wr(4'h8, 32'hAA);
        rd_access(4'h4);
        chk_pulse("R10 read aborts when enabled");
        do_reset();
        wr(4'h8, 32'hAA);
        wr(4'h4, 32'h500);
        chk("R10 disabled abort no req", {31'b0, sys_reset_req}, 0);
        peek(4'h4, v); chk("R10 interrupting write kept", v, 32'h500);
        wr(4'h8, 32'h55);
        peek(4'hC, v); chk("R10 lone close no reload", v, 32'hFF);
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'h56);
        chk("R10 disabled bad key no req", {31'b0, sys_reset_req}, 0);
    endtask

    task automatic t_stray_and_gap();
        logic [31:0] v;
        do_reset();
        wr(4'h0, 32'h1);
        wr(4'h4, 32'h400);
        wr(4'h8, 32'h12);
        chk("R11 stray write no req", {31'b0, sys_reset_req}, 0);
        wr(4'h8, 32'h55);
        chk("R11 lone close no req", {31'b0, sys_reset_req}, 0);
        peek(4'hC, v); chk("R11 no reload", v, 32'hFF);
        feed(3);
        chk("R5 gap feed no req", {31'b0, sys_reset_req}, 0);
        peek(4'hC, v); chk("R5 gap feed reload", v, 32'h400);
    endtask

    task automatic t_expire_reset();
        logic [31:0] v;
        do_reset();
        wr(4'h0, 32'h3);
        feed(0);
        repeat (1023) @(posedge clk); @(negedge clk);
        peek(4'hC, v); chk("R7 count at zero", v, 32'h0);
        chk("R7 flag not yet", {31'b0, expired_flag}, 0);
        chk("R8 req not yet", {31'b0, sys_reset_req}, 0);
        @(posedge clk); @(negedge clk);
        chk("R7 flag set", {31'b0, expired_flag}, 1);
        chk_pulse("R8 expiry pulse");
        peek(4'h0, v); chk("R7 ctrl shows flag", v, 32'h7);
        repeat (20) @(negedge clk);
        peek(4'hC, v); chk("R7 stopped at zero", v, 32'h0);
        feed(0);
        chk("R7 flag sticky over feed", {31'b0, expired_flag}, 1);
    endtask

    task automatic t_expire_quiet();
        logic [31:0] v;
        int seen;
        seen = 0;
        do_reset();
        wr(4'h0, 32'h1);
        feed(0);
        for (int i = 0; i < 1040; i++) begin
            @(negedge clk);
            if (sys_reset_req) seen++;
        end
        chk("R8 no req without reset mode", seen, 0);
        chk("R7 flag without reset mode", {31'b0, expired_flag}, 1);
        peek(4'hC, v); chk("R7 count held", v, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_reload_reg();
        t_ctrl_sticky();
        t_feed_disabled();
        t_start_count();
        t_bad_value();
        t_abort();
        t_stray_and_gap();
        t_expire_reset();
        t_expire_quiet();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule